// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block owns the fetch program counter and the fetch-to-decode pipeline register of a five-stage pipeline. It resolves conditional branches one stage after fetch instead of three. Every cycle it adds 4 to the fetch address. The word fetched from instruction memory is latched together with its sequential next address. When that word reaches decode and is a branch, the block tests one bypassed register value for zero or nonzero. It also forms the target from the latched next address and the word's immediate, and steers the next fetch.

A parameter picks one of two redirect policies. In squash mode the fall-through word fetched behind a taken branch is killed, so a taken branch costs one cycle and an untaken branch costs none. In delay-slot mode that same word always proceeds, and control moves to the target only after it. The test register can be the destination of a load that has not yet delivered its data. In that case the block holds fetch and decode until the value can be bypassed. The asynchronous active-low reset is released through a small synchronizer.

Top module: `early_branch_ctl`

## Requirements
- R1: While reset is asserted, fetch_pc equals RESET_PC, ifid_valid is 0, ifid_instr and ifid_npc are 0, and stall and flush are 0; the state stays there until the synchronized reset is released.
- R2: When no branch is taken and no stall is raised, fetch_pc advances by 4 every cycle, and the fetch-to-decode register captures fetch_instr with ifid_npc equal to the old fetch_pc plus 4 and ifid_valid set to 1.
- R3: A decode word is a branch when ifid_valid is 1 and bits [31:26] equal 6'b000100 (taken when test_val is zero) or 6'b000101 (taken when test_val is nonzero); the tested register number is bits [25:21].
- R4: The branch target is ifid_npc plus the 16-bit immediate in bits [15:0], sign-extended from bit 15 and shifted left by two.
- R5: An untaken branch raises no flush and costs no cycle: fetch_pc continues by 4 and the following word enters decode.
- R6: In squash mode (DELAY_SLOT=0) a taken branch raises flush for that cycle, the next fetch_pc is the target, and the decode register becomes an invalid no-op (ifid_valid 0, ifid_instr and ifid_npc 0).
- R7: In delay-slot mode (DELAY_SLOT=1) a taken branch never raises flush, the word fetched behind the branch enters decode as valid, and the next fetch_pc is the target.
- R8: When a decode branch tests register s (nonzero) and a load with destination s is in execute (ex_load, ex_rd) or in memory (mem_load, mem_rd), stall is 1, fetch_pc and the decode register hold, and no redirect happens until the hazard clears.
- R9: A branch that tests register 0 never stalls, even if a load names register 0 as destination.
- R10: stall and flush are never both 1, and neither is raised unless a valid branch sits in decode; a non-branch word ignores test_val and load inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | output | PC_W | Address being fetched this cycle |
| fetch_instr | input | 32 | Instruction word read at fetch_pc |
| ifid_instr | output | 32 | Instruction word held in decode |
| ifid_npc | output | PC_W | Sequential next address of the decode word |
| ifid_valid | output | 1 | Decode word is a live instruction |
| test_val | input | XLEN | Bypassed value of the tested register |
| ex_load | input | 1 | A load occupies execute |
| ex_rd | input | 5 | Destination register of that load |
| mem_load | input | 1 | A load occupies memory access |
| mem_rd | input | 5 | Destination register of that load |
| stall | output | 1 | Hold fetch and decode, insert a bubble into execute |
| flush | output | 1 | Fall-through word is squashed this cycle |

## Verification
The bound checker watches the per-cycle rules: the fetch address and decode register freeze while stall is high, the flush-to-target redirect and the resulting invalid no-op, stepping by 4 whenever decode holds no branch, and the fact that stall and flush only come from a valid branch with a matching load destination. Some behaviour only the bench scenarios show. These are the taken or untaken verdict for both opcodes against zero and nonzero operands, negative offsets, the register-0 exemption, and the delay-slot policy keeping the fall-through word. The bench shows them by running a squash-mode and a delay-slot-mode instance side by side against a reference model.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;

  localparam logic [5:0]         OPC_BR_ZERO    = 6'b000100;
  localparam logic [5:0]         OPC_BR_NONZERO = 6'b000101;
  localparam logic [INSTR_W-1:0] NOP_WORD       = '0;

  typedef struct packed {
    logic [5:0]       opc;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] aux;
    logic [IMM_W-1:0] imm;
  } instr_t;
endpackage

// File: rtl/ebr_rst_sync.sv
module ebr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ebr_fetch_pc.sv
module ebr_fetch_pc #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] pc_seq
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic            pc_en;
  logic [PC_W-1:0] pc_d;

  assign pc_seq = pc_q + STEP;
  assign pc_en  = !hold;

  always_comb begin
    pc_d = pc_seq;
    if (redirect) pc_d = target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end
endmodule

// File: rtl/ebr_ifid.sv
module ebr_ifid #(
  parameter int PC_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hold,
  input  logic                        squash,
  input  logic [ebr_pkg::INSTR_W-1:0] fetch_instr,
  input  logic [PC_W-1:0]             pc_seq,
  output logic [ebr_pkg::INSTR_W-1:0] instr_q,
  output logic [PC_W-1:0]             npc_q,
  output logic                        valid_q
);
  import ebr_pkg::*;

  logic               load_en;
  logic [INSTR_W-1:0] instr_d;
  logic [PC_W-1:0]    npc_d;
  logic               valid_d;

  assign load_en = !hold;

  always_comb begin
    if (squash) begin
      instr_d = NOP_WORD;
      npc_d   = '0;
      valid_d = 1'b0;
    end else begin
      instr_d = fetch_instr;
      npc_d   = pc_seq;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= NOP_WORD;
      npc_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_en) begin
      instr_q <= instr_d;
      npc_q   <= npc_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/ebr_branch_eval.sv
module ebr_branch_eval #(
  parameter int PC_W = 32,
  parameter int XLEN = 32
) (
  input  logic [ebr_pkg::INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]             npc,
  input  logic                        valid,
  input  logic [XLEN-1:0]             test_val,
  input  logic                        ex_load,
  input  logic [ebr_pkg::REG_W-1:0]   ex_rd,
  input  logic                        mem_load,
  input  logic [ebr_pkg::REG_W-1:0]   mem_rd,
  output logic                        hazard,
  output logic                        taken,
  output logic [PC_W-1:0]             target
);
  import ebr_pkg::*;

  localparam int EXT_W = PC_W - IMM_W - 2;

  instr_t          word;
  logic            is_bz;
  logic            is_bnz;
  logic            is_br;
  logic            op_zero;
  logic            src_live;
  logic            ex_hit;
  logic            mem_hit;
  logic [PC_W-1:0] offset;

  assign word = instr_t'(instr);

  always_comb begin
    is_bz    = valid && (word.opc == OPC_BR_ZERO);
    is_bnz   = valid && (word.opc == OPC_BR_NONZERO);
    is_br    = is_bz || is_bnz;
    op_zero  = ~|test_val;
    src_live = |word.src;
    ex_hit   = ex_load  && (ex_rd  == word.src);
    mem_hit  = mem_load && (mem_rd == word.src);
    hazard   = is_br && src_live && (ex_hit || mem_hit);
    taken    = !hazard && ((is_bz && op_zero) || (is_bnz && !op_zero));
    offset   = {{EXT_W{word.imm[IMM_W-1]}}, word.imm, 2'b00};
    target   = npc + offset;
  end
endmodule

// File: rtl/early_branch_ctl.sv
module early_branch_ctl #(
  parameter int              PC_W        = 32,
  parameter int              XLEN        = 32,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter int              DELAY_SLOT  = 0,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic [PC_W-1:0]             fetch_pc,
  input  logic [ebr_pkg::INSTR_W-1:0] fetch_instr,
  output logic [ebr_pkg::INSTR_W-1:0] ifid_instr,
  output logic [PC_W-1:0]             ifid_npc,
  output logic                        ifid_valid,
  input  logic [XLEN-1:0]             test_val,
  input  logic                        ex_load,
  input  logic [ebr_pkg::REG_W-1:0]   ex_rd,
  input  logic                        mem_load,
  input  logic [ebr_pkg::REG_W-1:0]   mem_rd,
  output logic                        stall,
  output logic                        flush
);
  logic            rst_q_n;
  logic            hazard;
  logic            taken;
  logic            squash;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] pc_seq;

  ebr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  ebr_fetch_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .hold     (hazard),
    .redirect (taken),
    .target   (target),
    .pc_q     (fetch_pc),
    .pc_seq   (pc_seq)
  );

  ebr_ifid #(.PC_W(PC_W)) u_ifid (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .hold        (hazard),
    .squash      (squash),
    .fetch_instr (fetch_instr),
    .pc_seq      (pc_seq),
    .instr_q     (ifid_instr),
    .npc_q       (ifid_npc),
    .valid_q     (ifid_valid)
  );

  ebr_branch_eval #(.PC_W(PC_W), .XLEN(XLEN)) u_eval (
    .instr    (ifid_instr),
    .npc      (ifid_npc),
    .valid    (ifid_valid),
    .test_val (test_val),
    .ex_load  (ex_load),
    .ex_rd    (ex_rd),
    .mem_load (mem_load),
    .mem_rd   (mem_rd),
    .hazard   (hazard),
    .taken    (taken),
    .target   (target)
  );

  generate
    if (DELAY_SLOT != 0) begin : g_delay
      assign squash = 1'b0;
    end else begin : g_squash
      assign squash = taken;
    end
  endgenerate

  assign stall = hazard;
  assign flush = squash;
endmodule

// File: rtl/ebr_chk.sv
module ebr_chk #(
  parameter int PC_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [PC_W-1:0]             fetch_pc,
  input logic [ebr_pkg::INSTR_W-1:0] ifid_instr,
  input logic [PC_W-1:0]             ifid_npc,
  input logic                        ifid_valid,
  input logic                        ex_load,
  input logic [ebr_pkg::REG_W-1:0]   ex_rd,
  input logic                        mem_load,
  input logic [ebr_pkg::REG_W-1:0]   mem_rd,
  input logic                        stall,
  input logic                        flush
);
  import ebr_pkg::*;

  logic            dec_br;
  logic [4:0]      dec_src;
  logic            load_match;
  logic [PC_W-1:0] dec_tgt;

  assign dec_br  = ifid_valid && (ifid_instr[31:26] == OPC_BR_ZERO ||
                                  ifid_instr[31:26] == OPC_BR_NONZERO);
  assign dec_src = ifid_instr[25:21];
  assign load_match = (ex_load && ex_rd == dec_src) || (mem_load && mem_rd == dec_src);
  assign dec_tgt = ifid_npc + {{(PC_W-18){ifid_instr[15]}}, ifid_instr[15:0], 2'b00};

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_pc) && $stable(ifid_instr) && $stable(ifid_npc));

  assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> dec_br && (dec_src != 5'd0) && load_match);

  assert_flush_kills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ifid_valid && (ifid_instr == NOP_WORD));

  assert_flush_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_pc == $past(dec_tgt));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !dec_br) |=> fetch_pc == $past(fetch_pc) + PC_W'(4));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall, flush}) && (flush -> dec_br));
endmodule

bind early_branch_ctl ebr_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .fetch_pc   (fetch_pc),
  .ifid_instr (ifid_instr),
  .ifid_npc   (ifid_npc),
  .ifid_valid (ifid_valid),
  .ex_load    (ex_load),
  .ex_rd      (ex_rd),
  .mem_load   (mem_load),
  .mem_rd     (mem_rd),
  .stall      (stall),
  .flush      (flush)
);

// File: tb/early_branch_ctl_bench.sv
`timescale 1ns/1ps
module early_branch_ctl_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_instr = '0;
  logic [31:0] test_val = '0;
  logic        ex_load = 1'b0;
  logic [4:0]  ex_rd = '0;
  logic        mem_load = 1'b0;
  logic [4:0]  mem_rd = '0;

  logic [31:0] pc_o [2];
  logic [31:0] ins_o [2];
  logic [31:0] npc_o [2];
  logic        val_o [2];
  logic        stl_o [2];
  logic        fl_o [2];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  early_branch_ctl #(.RESET_PC(RST_PC), .DELAY_SLOT(0)) u_early_branch_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_pc(pc_o[0]), .fetch_instr(fetch_instr),
    .ifid_instr(ins_o[0]), .ifid_npc(npc_o[0]), .ifid_valid(val_o[0]),
    .test_val(test_val), .ex_load(ex_load), .ex_rd(ex_rd),
    .mem_load(mem_load), .mem_rd(mem_rd), .stall(stl_o[0]), .flush(fl_o[0]));

  early_branch_ctl #(.RESET_PC(RST_PC), .DELAY_SLOT(1)) u_early_branch_ctl_dly (
    .clk(clk), .rst_n(rst_n), .fetch_pc(pc_o[1]), .fetch_instr(fetch_instr),
    .ifid_instr(ins_o[1]), .ifid_npc(npc_o[1]), .ifid_valid(val_o[1]),
    .test_val(test_val), .ex_load(ex_load), .ex_rd(ex_rd),
    .mem_load(mem_load), .mem_rd(mem_rd), .stall(stl_o[1]), .flush(fl_o[1]));

  logic [31:0] m_pc [2];
  logic [31:0] m_ins [2];
  logic [31:0] m_npc [2];
  logic        m_val [2];

  function automatic logic [31:0] mk_br(input bit nz, input logic [4:0] s, input logic [15:0] imm);
    return {5'b00010, nz, s, 5'd0, imm};
  endfunction

  function automatic logic [31:0] br_target(input logic [31:0] npc, input logic [31:0] ins);
    return npc + {{14{ins[15]}}, ins[15:0], 2'b00};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string force_tag);
    #1;
    for (int m = 0; m < 2; m++) begin
      bit br, bz, haz, tk;
      logic [4:0] s;
      string tag;
      bz  = m_val[m] && m_ins[m][31:26] == 6'b000100;
      br  = bz || (m_val[m] && m_ins[m][31:26] == 6'b000101);
      s   = m_ins[m][25:21];
      haz = br && s != 5'd0 && ((ex_load && ex_rd == s) || (mem_load && mem_rd == s));
      tk  = br && !haz && (bz == (test_val == 32'd0));
      if (force_tag != "") tag = force_tag;
      else if (haz) tag = "R8";
      else if (tk) tag = (m == 0) ? "R6" : "R7";
      else if (br) tag = "R5";
      else tag = "R2";
      chk(tag, "fetch_pc", pc_o[m], m_pc[m]);
      chk(tag, "ifid_instr", ins_o[m], m_ins[m]);
      chk(tag, "ifid_npc", npc_o[m], m_npc[m]);
      chk(tag, "ifid_valid", 32'(val_o[m]), 32'(m_val[m]));
      chk(tag, "stall", 32'(stl_o[m]), 32'(haz));
      chk(tag, "flush", 32'(fl_o[m]), 32'(tk && m == 0));
      if (!haz) begin
        if (tk && m == 0) begin
          m_ins[m] = '0; m_npc[m] = '0; m_val[m] = 1'b0;
        end else begin
          m_ins[m] = fetch_instr; m_npc[m] = m_pc[m] + 32'd4; m_val[m] = 1'b1;
        end
        m_pc[m] = tk ? br_target(npc_o[m], ins_o[m]) : m_pc[m] + 32'd4;
      end
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] fi, input logic [31:0] tv, input bit el,
                       input logic [4:0] er, input bit ml, input logic [4:0] mr, input string tag);
    fetch_instr = fi; test_val = tv; ex_load = el; ex_rd = er; mem_load = ml; mem_rd = mr;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1", "reset fetch_pc", pc_o[m], RST_PC);
      chk("R1", "reset ifid_instr", ins_o[m], 32'd0);
      chk("R1", "reset ifid_npc", npc_o[m], 32'd0);
      chk("R1", "reset ifid_valid", 32'(val_o[m]), 32'd0);
      chk("R1", "reset stall", 32'(stl_o[m]), 32'd0);
      chk("R1", "reset flush", 32'(fl_o[m]), 32'd0);
      m_pc[m] = RST_PC; m_ins[m] = '0; m_npc[m] = '0; m_val[m] = 1'b0;
    end
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) chk("R1", "held by synchronizer", pc_o[m], RST_PC);

    // directed: plain sequence, then taken branch-if-zero
    drive(32'h2000_0001, 32'd5, 0, 0, 0, 0, "R2");
    drive(mk_br(0, 5'd3, 16'h0010), 32'd5, 0, 0, 0, 0, "R2");
    drive(32'h2000_0002, 32'd0, 0, 0, 0, 0, "R3");
    drive(32'h2000_0003, 32'd0, 0, 0, 0, 0, "");
    // untaken branch-if-nonzero with zero operand
    drive(mk_br(1, 5'd4, 16'h0004), 32'd0, 0, 0, 0, 0, "");
    drive(32'h2000_0004, 32'd0, 0, 0, 0, 0, "R5");
    // backward target, sign extension
    drive(mk_br(1, 5'd2, 16'hFFF8), 32'd7, 0, 0, 0, 0, "");
    drive(32'h2000_0005, 32'd7, 0, 0, 0, 0, "R4");
    drive(32'h2000_0006, 32'd7, 0, 0, 0, 0, "R4");
    // load in memory stage on tested register: stall, then resolve
    drive(mk_br(0, 5'd6, 16'h0002), 32'd0, 0, 0, 0, 0, "");
    drive(32'h2000_0007, 32'd0, 0, 0, 1, 5'd6, "R8");
    drive(32'h2000_0007, 32'd0, 1, 5'd6, 0, 0, "R8");
    drive(32'h2000_0007, 32'd0, 0, 0, 0, 0, "R6");
    drive(32'h2000_0008, 32'd0, 0, 0, 0, 0, "");
    // register 0 never stalls
    drive(mk_br(0, 5'd0, 16'h0003), 32'd0, 0, 0, 0, 0, "");
    drive(32'h2000_0009, 32'd0, 1, 5'd0, 1, 5'd0, "R9");
    drive(32'h2000_000A, 32'd0, 0, 0, 0, 0, "R9");
    // non-branch opcode with zero operand and matching load: no effect
    drive(32'h1860_0005, 32'd0, 0, 0, 0, 0, "");
    drive(32'h2000_000B, 32'd0, 1, 5'd3, 1, 5'd3, "R10");
    drive(32'h2000_000C, 32'd0, 0, 0, 0, 0, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] fi;
      logic [31:0] rv;
      rv = $urandom;
      if (rv[2:0] < 3) fi = mk_br(rv[3], 5'(rv[6:4]), 16'($urandom));
      else if (rv[2:0] == 3) fi = {6'b000110, 26'($urandom)};
      else fi = $urandom;
      drive(fi, rv[8] ? 32'd0 : $urandom, rv[10:9] == 2'b00, 5'(rv[13:11]),
            rv[15:14] == 2'b00, 5'(rv[18:16]), "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule